// File: doc/BRIEF.md
# Programmable Prescaled Timer Unit

This peripheral counts cycle ticks on a 16-bit divider and shows the divider's upper byte as a readable register. A second 8-bit counter, when enabled, advances once every N ticks. N is chosen by a two-bit rate field in the control register. When that counter steps past its all-ones value it is reloaded from a modulo register rather than wrapping to zero. At the same moment a one-cycle interrupt pulse is raised, which a separate interrupt flag register can latch.

Software reaches the block through a plain register port: an offset, write data with a write strobe, and read data that is decoded from the offset combinationally. The tick input says when one processor cycle has elapsed. Bus decoding and interrupt flag storage are outside this block. Every input here is a control pin and no data stream crosses the boundary, so the block has no valid/ready handshake and never applies back-pressure. A write always lands on the clock edge at which its strobe is sampled.

Top module: `tmr_unit`

## Requirements
- R1: After reset the internal divider holds 0xABCC, so offset 0x00 reads 0xAB. The counter (offset 0x01) and the modulo (offset 0x02) read 0x00, the control register (offset 0x03) reads 0xF8, the prescaler is cleared and `irq_pulse` is low.
- R2: Each clock edge with `cyc_tick` high adds one to the 16-bit divider. Offset 0x00 always reads the divider's upper eight bits.
- R3: A write to offset 0x00 clears the entire 16-bit divider and the prescaler, whatever the data is.
- R4: Control bits [1:0] set the number of enabled ticks per counter step: 0 gives 1024, 1 gives 16, 2 gives 64 and 3 gives 256. After the prescaler is cleared, the step happens on exactly the N-th tick.
- R5: While control bit 2 is 0, the counter and the prescaler hold, and the divider keeps advancing.
- R6: A step taken from 0xFF loads the counter with the modulo register value instead of 0x00.
- R7: `irq_pulse` goes high for exactly one clock cycle, in the cycle in which the reloaded value first becomes visible at offset 0x01.
- R8: Reads of the control register return bits [7:3] as 1 and bits [2:0] as the last value written.
- R9: A write to the control register clears the prescaler, so a new rate is counted from the write.
- R10: Writes to the counter and the modulo store the full byte. Writes to any offset other than 0x00 to 0x03 change nothing, and reads from those offsets return 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_tick | input | 1 | One processor cycle has elapsed |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register offset for reads and writes |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| irq_pulse | output | 1 | One-cycle counter overflow request |

## Verification
A prescaler holding a stale or wrong count shows up at the counter offset as a step that comes early or late. It is off by at least one tick, on the first step after the prescaler is cleared. A divider that is not cleared, or that has slipped, shows in the divider byte within 256 ticks of the fault. A reload taken from the wrong place shows at the counter offset on the very clock that raises `irq_pulse`. A pulse that is stuck or doubled shows up in the count of high cycles.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int REG_DIV  = 0;
  localparam int REG_CNT  = 1;
  localparam int REG_MOD  = 2;
  localparam int REG_CTRL = 3;
  localparam int CTRL_W   = 3;
  localparam int RATE_N   = 4;
  localparam int MAX_PERIOD = 1024;

  function automatic int period_of(input int sel);
    case (sel)
      0: return 1024;
      1: return 16;
      2: return 64;
      default: return 256;
    endcase
  endfunction
endpackage

// File: rtl/tmr_divider.sv
module tmr_divider #(
  parameter int DIV_W = 16,
  parameter logic [DIV_W-1:0] RESET_VAL = 16'hABCC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  output logic [DIV_W-1:0] div_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    div_q <= RESET_VAL;
    else if (clr)  div_q <= '0;
    else if (tick) div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       en,
  input  logic [1:0] sel,
  input  logic       clr,
  output logic       step
);
  localparam int PW = $clog2(MAX_PERIOD);

  logic [PW-1:0] limit [RATE_N];
  logic [PW-1:0] acc_q;

  for (genvar g = 0; g < RATE_N; g++) begin : g_lim
    assign limit[g] = PW'(period_of(g) - 1);
  end

  assign step = en && tick && (acc_q == limit[sel]);

  always_ff @(posedge clk) begin
    if (!rst_n)          acc_q <= '0;
    else if (clr)        acc_q <= '0;
    else if (en && tick) acc_q <= step ? '0 : acc_q + 1'b1;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              wr_cnt,
  input  logic              wr_mod,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] cnt_q,
  output logic [DATA_W-1:0] mod_q,
  output logic              irq_q
);
  logic at_top;
  assign at_top = &cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mod_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= step && at_top && !wr_cnt;
      if (wr_mod) mod_q <= wr_data;
      if (wr_cnt)      cnt_q <= wr_data;
      else if (step)   cnt_q <= at_top ? mod_q : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16,
  parameter logic [DIV_W-1:0] DIV_RESET = 16'hABCC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_pulse
);
  localparam int PAD_W = DATA_W - CTRL_W;

  logic [DIV_W-1:0]  div_val;
  logic [DATA_W-1:0] cnt_val, mod_val;
  logic [CTRL_W-1:0] ctrl_q;
  logic wr_div, wr_cnt, wr_mod, wr_ctrl, step;

  assign wr_div  = wr_en && (addr == ADDR_W'(REG_DIV));
  assign wr_cnt  = wr_en && (addr == ADDR_W'(REG_CNT));
  assign wr_mod  = wr_en && (addr == ADDR_W'(REG_MOD));
  assign wr_ctrl = wr_en && (addr == ADDR_W'(REG_CTRL));

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= wr_data[CTRL_W-1:0];
  end

  tmr_divider #(.DIV_W(DIV_W), .RESET_VAL(DIV_RESET)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(cyc_tick), .clr(wr_div), .div_q(div_val)
  );

  tmr_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .tick(cyc_tick), .en(ctrl_q[2]),
    .sel(ctrl_q[1:0]), .clr(wr_div || wr_ctrl), .step(step)
  );

  tmr_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .wr_cnt(wr_cnt), .wr_mod(wr_mod),
    .wr_data(wr_data), .cnt_q(cnt_val), .mod_q(mod_val), .irq_q(irq_pulse)
  );

  always_comb begin
    if (addr == ADDR_W'(REG_DIV))       rd_data = div_val[DIV_W-1 -: DATA_W];
    else if (addr == ADDR_W'(REG_CNT))  rd_data = cnt_val;
    else if (addr == ADDR_W'(REG_MOD))  rd_data = mod_val;
    else if (addr == ADDR_W'(REG_CTRL)) rd_data = {{PAD_W{1'b1}}, ctrl_q};
    else                                rd_data = '1;
  end
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cyc_tick,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              irq_pulse,
  input logic [DIV_W-1:0]  div_q,
  input logic [DATA_W-1:0] cnt_q,
  input logic [DATA_W-1:0] mod_q,
  input logic [CTRL_W-1:0] ctrl_q
);
  logic wr_d, wr_c;
  assign wr_d = wr_en && (addr == ADDR_W'(REG_DIV));
  assign wr_c = wr_en && (addr == ADDR_W'(REG_CNT));

  assert_div_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_tick && !wr_d) |=> div_q == DIV_W'($past(div_q) + 1'b1));

  assert_div_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_d |=> div_q == '0);

  assert_hold_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[2] && !wr_c) |=> $stable(cnt_q));

  assert_reload_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> cnt_q == $past(mod_q));

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);

  assert_ctrl_pad_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(REG_CTRL)) |-> &rd_data[DATA_W-1:CTRL_W]);
endmodule

bind tmr_unit tmr_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .wr_en(wr_en), .addr(addr),
  .rd_data(rd_data), .irq_pulse(irq_pulse), .div_q(div_val), .cnt_q(cnt_val),
  .mod_q(mod_val), .ctrl_q(ctrl_q)
);

// File: tb/tmr_unit_test.sv
module tmr_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_tick = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic irq_pulse;

  int checks = 0;
  int fails = 0;
  int irq_hi = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tmr_unit uut (
    .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq_pulse(irq_pulse)
  );

  always @(negedge clk) if (irq_pulse) irq_hi++;

  function automatic int period(input int sel);
    case (sel)
      0: return 1024;
      1: return 16;
      2: return 64;
      default: return 256;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc_tick = 1'b1;
    end
    @(negedge clk);
    cyc_tick = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(8'h00, v); check("R1 divider", v, 8'hAB);
    rd(8'h01, v); check("R1 counter", v, 8'h00);
    rd(8'h02, v); check("R1 modulo", v, 8'h00);
    rd(8'h03, v); check("R1 control", v, 8'hF8);
    check("R1 irq", irq_pulse, 0);
  endtask

  task automatic t_divider_run();
    logic [7:0] v;
    ticks(51); rd(8'h00, v); check("R2 before carry", v, 8'hAB);
    ticks(1);  rd(8'h00, v); check("R2 carry", v, 8'hAC);
  endtask

  task automatic t_divider_clear();
    logic [7:0] v;
    wr(8'h00, 8'h5A); rd(8'h00, v); check("R3 cleared", v, 8'h00);
    ticks(255); rd(8'h00, v); check("R3 low byte cleared", v, 8'h00);
    ticks(1);   rd(8'h00, v); check("R3 256 ticks", v, 8'h01);
    wr(8'h03, 8'h05); wr(8'h01, 8'h00);
    ticks(10); wr(8'h00, 8'h00);
    ticks(15); rd(8'h01, v); check("R3 prescaler cleared", v, 8'h00);
    ticks(1);  rd(8'h01, v); check("R3 step after clear", v, 8'h01);
  endtask

  task automatic t_rates();
    logic [7:0] v;
    for (int s = 0; s < 4; s++) begin
      wr(8'h03, 8'(4 + s)); wr(8'h01, 8'h20);
      ticks(period(s) - 1); rd(8'h01, v); check($sformatf("R4 sel%0d early", s), v, 8'h20);
      ticks(1);             rd(8'h01, v); check($sformatf("R4 sel%0d step", s), v, 8'h21);
    end
  endtask

  task automatic t_disable();
    logic [7:0] v;
    wr(8'h03, 8'h01); wr(8'h01, 8'h33); wr(8'h00, 8'h00);
    ticks(300);
    rd(8'h01, v); check("R5 counter held", v, 8'h33);
    rd(8'h00, v); check("R5 divider runs", v, 8'h01);
  endtask

  task automatic t_overflow();
    logic [7:0] v;
    wr(8'h02, 8'hF0); wr(8'h01, 8'hFE); wr(8'h03, 8'h05);
    irq_hi = 0;
    ticks(16); rd(8'h01, v); check("R6 at top", v, 8'hFF);
    check("R7 no early irq", irq_hi, 0);
    ticks(16); rd(8'h01, v); check("R6 reload", v, 8'hF0);
    check("R7 one pulse cycle", irq_hi, 1);
    rd(8'h02, v); check("R10 modulo stored", v, 8'hF0);
  endtask

  task automatic t_ctrl_read();
    logic [7:0] v;
    wr(8'h03, 8'h02); rd(8'h03, v); check("R8 pad ones", v, 8'hFA);
    wr(8'h03, 8'h05); rd(8'h03, v); check("R8 readback", v, 8'hFD);
  endtask

  task automatic t_rate_restart();
    logic [7:0] v;
    wr(8'h03, 8'h04); wr(8'h01, 8'h10);
    ticks(500); wr(8'h03, 8'h05);
    ticks(15); rd(8'h01, v); check("R9 restart early", v, 8'h10);
    ticks(1);  rd(8'h01, v); check("R9 restart step", v, 8'h11);
  endtask

  task automatic t_unmapped();
    logic [7:0] v;
    wr(8'h03, 8'h01); wr(8'h01, 8'h77); wr(8'h02, 8'h99);
    wr(8'h10, 8'h55); wr(8'h04, 8'h00); wr(8'h83, 8'h06);
    rd(8'h01, v); check("R10 counter kept", v, 8'h77);
    rd(8'h02, v); check("R10 modulo kept", v, 8'h99);
    rd(8'h03, v); check("R10 control kept", v, 8'hF9);
    rd(8'h10, v); check("R10 unmapped read", v, 8'hFF);
    rd(8'h04, v); check("R10 unmapped read 4", v, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_divider_run();
    t_divider_clear();
    t_rates();
    t_disable();
    t_overflow();
    t_ctrl_read();
    t_rate_restart();
    t_unmapped();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule